// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings the rows of a single-data-rate SDRAM array out of power-up before the memory controller is allowed to run normal traffic. After reset it first waits for supplies and clocks to settle. It then visits each populated row in ascending index order. For each such row it selects the row's chip-select and issues the standard bring-up command train: a NOP, a long settle wait, a precharge of all banks, eight auto-refresh commands, a mode-register load and a return to normal mode. The row is then exercised with a single write of a fixed check pattern to its base address, followed by a readback.

A row counts as populated when its cumulative boundary value is strictly larger than the boundary of the row below it. The boundary below row 0 is taken as zero. A row with no capacity of its own is therefore passed over without any bus activity. A readback that does not match the pattern sets a sticky error bit for that row, and the sequencer carries on. Once the last row is finished, refresh is enabled and, one cycle later, the completion flag is raised.

All waits are given in microseconds. They are turned into clock cycles from the clock-frequency parameter by rounding up, so no wait is ever shorter than its minimum.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, every strobe is low, `cs_n` is all ones, `addr` and `wdata` are zero, `cmd_mode` reads 1 (NOP), and `refresh_en`, `init_done` and `row_err` are zero.
- R2: The first command after reset leaves the sequencer exactly T200 cycles after reset is released, counting the first rising edge with reset low as cycle 1.
- R3: Row r reads its 8-bit boundary from `row_bound[8r+7:8r]`. The row is populated only when this value is greater than the boundary of row r-1 (row 0 is compared with 0). An unpopulated row receives no command, write or read.
- R4: For each populated row, in ascending index order, the strobes follow this sequence:
  - `cmd_vld` with mode 1 (NOP), then mode 2 (precharge all), then eight of mode 6 (auto refresh), then mode 3 (mode-register set), then mode 7 (normal);
  - then one `wr_en` and one `rd_en`.
  
  Each strobe lasts one cycle, and during a strobe only `cs_n[r]` is low.
- R5: Spacing between the starts of consecutive strobes:
  - NOP to precharge: T200;
  - precharge to first refresh, between refreshes, and last refresh to mode set: T1 each;
  - mode set to normal: T2;
  - normal to write: T1;
  - write to read: 1.
- R6: `addr` carries 0x1D0 during a mode-register-set strobe and is zero in every other cycle.
- R7: During the write strobe `wdata` is 0x55AA55AA and `addr` is 0. Outside the write strobe `wdata` is zero.
- R8: `rd_data` is sampled at the end of the cycle that comes RD_LAT cycles after the read-strobe cycle. A mismatch with 0x55AA55AA sets `row_err[r]`, and the bit stays set until reset. The next populated row's NOP comes RD_LAT+1 cycles after the read strobe, whether or not the readback matched.
- R9: `refresh_en` rises RD_LAT+1 cycles after the last read strobe, or T200 cycles after reset release when no row is populated. `init_done` rises one cycle later. Both then stay high and no further strobe occurs.
- R10: Each wait is the clock frequency in kHz times its length in µs, divided by 1000 and rounded up. At 5500 kHz this gives T1 = 6, T2 = 11 and T200 = 1100.
- R11: Between strobes `cmd_mode` holds the mode of the most recent command strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_bound | input | NUM_ROWS*BND_W | Cumulative row boundaries, row r in field r |
| rd_data | input | DATA_W | Read data returned by the memory |
| cmd_vld | output | 1 | One-cycle command strobe |
| cmd_mode | output | 3 | Mode-select code of the latest command |
| cs_n | output | NUM_ROWS | Active-low chip select per row |
| addr | output | ADDR_W | Address bus (mode value during mode set) |
| wr_en | output | 1 | Check-pattern write strobe |
| rd_en | output | 1 | Check-pattern read strobe |
| wdata | output | DATA_W | Write data |
| refresh_en | output | 1 | Periodic refresh enable |
| init_done | output | 1 | Initialization complete |
| row_err | output | NUM_ROWS | Sticky per-row readback error |

## Verification
The bench aims at boundary layouts that mix populated rows with empty, equal and decreasing boundaries. If the skip rule were wrong, a row would be issued commands it should not get, or a real row would be missed, and the cycle-by-cycle comparison would catch the stray or missing strobe. One run uses a clock frequency that does not divide evenly into 1 µs. A design that truncated instead of rounding up would issue its refreshes a cycle early.

The responder drives valid read data only in the one cycle where the sample is due. A latency off by one would then capture filler data and raise a false row error. Other runs corrupt the readback of the last row and of the first row. A design that stopped on the error, or failed to keep the bit, would show a missing command train or a cleared flag. The run with no populated row checks that refresh and completion still follow after the power-up wait.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    MS_SELF   = 3'd0,
    MS_NOP    = 3'd1,
    MS_PRE    = 3'd2,
    MS_MRS    = 3'd3,
    MS_CBR    = 3'd6,
    MS_NORMAL = 3'd7
  } mode_e;

  typedef enum logic [3:0] {
    ST_PWR,
    ST_NOP,
    ST_PRE,
    ST_CBR,
    ST_MRS,
    ST_NRM,
    ST_WR,
    ST_RD,
    ST_REF,
    ST_DONE
  } seq_state_e;

  // Wait length in cycles, rounded up so that a wait is never short.
  function automatic int unsigned us_to_cycles(input int unsigned us,
                                               input int unsigned khz);
    return (us * khz + 999) / 1000;
  endfunction

endpackage

// File: rtl/sdram_row_sel.sv
module sdram_row_sel #(
  parameter int NUM_ROWS = 4,
  parameter int BND_W    = 8,
  localparam int ROW_W   = $clog2(NUM_ROWS)
) (
  input  logic [NUM_ROWS*BND_W-1:0] row_bound,
  input  logic [ROW_W-1:0]          cur_row,
  output logic                      first_vld,
  output logic [ROW_W-1:0]          first_idx,
  output logic                      next_vld,
  output logic [ROW_W-1:0]          next_idx
);

  logic [NUM_ROWS-1:0] populated;

  // A row holds memory only when its boundary climbs above the one below.
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_pop
    if (r == 0) begin : g_base
      assign populated[r] = row_bound[BND_W-1:0] != '0;
    end else begin : g_upper
      assign populated[r] = row_bound[r*BND_W +: BND_W] >
                            row_bound[(r-1)*BND_W +: BND_W];
    end
  end

  always_comb begin
    first_vld = 1'b0;
    first_idx = '0;
    next_vld  = 1'b0;
    next_idx  = '0;
    for (int r = NUM_ROWS - 1; r >= 0; r--) begin
      if (populated[r]) begin
        first_vld = 1'b1;
        first_idx = ROW_W'(r);
        if (ROW_W'(r) > cur_row) begin
          next_vld = 1'b1;
          next_idx = ROW_W'(r);
        end
      end
    end
  end

endmodule

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
  parameter int          CNT_W   = 12,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_check_unit.sv
module sdram_check_unit #(
  parameter int                   NUM_ROWS  = 4,
  parameter int                   DATA_W    = 32,
  parameter logic [DATA_W-1:0]    CHECK_PAT = 32'h55AA55AA,
  localparam int                  ROW_W     = $clog2(NUM_ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                capture,
  input  logic [ROW_W-1:0]    row,
  input  logic [DATA_W-1:0]   rd_data,
  output logic [NUM_ROWS-1:0] err
);

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst) begin
        err[r] <= 1'b0;
      end else if (capture && row == ROW_W'(r) && rd_data != CHECK_PAT) begin
        err[r] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int                CLK_KHZ   = 100000,
  parameter int                NUM_ROWS  = 4,
  parameter int                BND_W     = 8,
  parameter int                ADDR_W    = 13,
  parameter int                DATA_W    = 32,
  parameter int                RD_LAT    = 2,
  parameter int                NUM_CBR   = 8,
  parameter logic [ADDR_W-1:0] MODE_VAL  = 13'h1D0,
  parameter logic [DATA_W-1:0] CHECK_PAT = 32'h55AA55AA
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_ROWS*BND_W-1:0] row_bound,
  input  logic [DATA_W-1:0]         rd_data,
  output logic                      cmd_vld,
  output logic [2:0]                cmd_mode,
  output logic [NUM_ROWS-1:0]       cs_n,
  output logic [ADDR_W-1:0]         addr,
  output logic                      wr_en,
  output logic                      rd_en,
  output logic [DATA_W-1:0]         wdata,
  output logic                      refresh_en,
  output logic                      init_done,
  output logic [NUM_ROWS-1:0]       row_err
);

  localparam int unsigned T_PWR  = us_to_cycles(200, CLK_KHZ);
  localparam int unsigned T_NOP  = us_to_cycles(200, CLK_KHZ);
  localparam int unsigned T_STEP = us_to_cycles(1, CLK_KHZ);
  localparam int unsigned T_MRS  = us_to_cycles(2, CLK_KHZ);
  localparam int unsigned T_RD   = RD_LAT;
  localparam int unsigned MAXW0  = (T_PWR > T_NOP) ? T_PWR : T_NOP;
  localparam int unsigned MAXW   = (MAXW0 > T_RD + 1) ? MAXW0 : T_RD + 1;
  localparam int          CNT_W  = $clog2(MAXW + 1);
  localparam int          ROW_W  = $clog2(NUM_ROWS);
  localparam int          CBR_W  = $clog2(NUM_CBR + 1);

  seq_state_e         st_q, st_d;
  logic [ROW_W-1:0]   row_q, row_d, iss_row;
  logic [CBR_W-1:0]   cbr_q, cbr_d;
  logic               tmr_zero, ld;
  logic [CNT_W-1:0]   ld_val;
  logic               first_vld, next_vld;
  logic [ROW_W-1:0]   first_idx, next_idx;
  logic               iss_cmd, iss_wr, iss_rd, ref_set, done_set, cap;
  mode_e              iss_mode;
  logic [NUM_ROWS-1:0] sel_row;

  sdram_row_sel #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W)) u_row_sel (
    .row_bound (row_bound),
    .cur_row   (row_q),
    .first_vld (first_vld),
    .first_idx (first_idx),
    .next_vld  (next_vld),
    .next_idx  (next_idx)
  );

  sdram_wait_timer #(.CNT_W(CNT_W), .RST_VAL(T_PWR - 1)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .zero     (tmr_zero)
  );

  sdram_check_unit #(.NUM_ROWS(NUM_ROWS), .DATA_W(DATA_W), .CHECK_PAT(CHECK_PAT)) u_check (
    .clk     (clk),
    .rst     (rst),
    .capture (cap),
    .row     (row_q),
    .rd_data (rd_data),
    .err     (row_err)
  );

  // Each step fires when the wait loaded by the previous step has run out.
  always_comb begin
    st_d     = st_q;
    row_d    = row_q;
    cbr_d    = cbr_q;
    ld       = 1'b0;
    ld_val   = '0;
    iss_cmd  = 1'b0;
    iss_mode = MS_NOP;
    iss_wr   = 1'b0;
    iss_rd   = 1'b0;
    iss_row  = row_q;
    ref_set  = 1'b0;
    done_set = 1'b0;
    cap      = 1'b0;
    if (tmr_zero) begin
      unique case (st_q)
        ST_PWR: begin
          if (first_vld) begin
            iss_cmd = 1'b1; iss_mode = MS_NOP; iss_row = first_idx;
            row_d = first_idx; st_d = ST_NOP;
            ld = 1'b1; ld_val = CNT_W'(T_NOP - 1);
          end else begin
            ref_set = 1'b1; st_d = ST_REF; ld = 1'b1;
          end
        end
        ST_NOP: begin
          iss_cmd = 1'b1; iss_mode = MS_PRE; st_d = ST_PRE;
          ld = 1'b1; ld_val = CNT_W'(T_STEP - 1);
        end
        ST_PRE: begin
          iss_cmd = 1'b1; iss_mode = MS_CBR; st_d = ST_CBR;
          cbr_d = CBR_W'(1);
          ld = 1'b1; ld_val = CNT_W'(T_STEP - 1);
        end
        ST_CBR: begin
          iss_cmd = 1'b1; ld = 1'b1;
          if (cbr_q < CBR_W'(NUM_CBR)) begin
            iss_mode = MS_CBR; cbr_d = cbr_q + 1'b1;
            ld_val = CNT_W'(T_STEP - 1);
          end else begin
            iss_mode = MS_MRS; st_d = ST_MRS;
            ld_val = CNT_W'(T_MRS - 1);
          end
        end
        ST_MRS: begin
          iss_cmd = 1'b1; iss_mode = MS_NORMAL; st_d = ST_NRM;
          ld = 1'b1; ld_val = CNT_W'(T_STEP - 1);
        end
        ST_NRM: begin
          iss_wr = 1'b1; st_d = ST_WR; ld = 1'b1;
        end
        ST_WR: begin
          iss_rd = 1'b1; st_d = ST_RD;
          ld = 1'b1; ld_val = CNT_W'(T_RD);
        end
        ST_RD: begin
          cap = 1'b1;
          if (next_vld) begin
            iss_cmd = 1'b1; iss_mode = MS_NOP; iss_row = next_idx;
            row_d = next_idx; st_d = ST_NOP;
            ld = 1'b1; ld_val = CNT_W'(T_NOP - 1);
          end else begin
            ref_set = 1'b1; st_d = ST_REF; ld = 1'b1;
          end
        end
        ST_REF: begin
          done_set = 1'b1; st_d = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_ROWS; r++) begin
      sel_row[r] = (iss_row == ROW_W'(r));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_PWR;
      row_q      <= '0;
      cbr_q      <= '0;
      cmd_vld    <= 1'b0;
      cmd_mode   <= MS_NOP;
      cs_n       <= '1;
      addr       <= '0;
      wr_en      <= 1'b0;
      rd_en      <= 1'b0;
      wdata      <= '0;
      refresh_en <= 1'b0;
      init_done  <= 1'b0;
    end else begin
      st_q       <= st_d;
      row_q      <= row_d;
      cbr_q      <= cbr_d;
      cmd_vld    <= iss_cmd;
      if (iss_cmd) cmd_mode <= iss_mode;
      cs_n       <= (iss_cmd || iss_wr || iss_rd) ? ~sel_row : '1;
      addr       <= (iss_cmd && iss_mode == MS_MRS) ? MODE_VAL : '0;
      wr_en      <= iss_wr;
      rd_en      <= iss_rd;
      wdata      <= iss_wr ? CHECK_PAT : '0;
      refresh_en <= refresh_en || ref_set;
      init_done  <= init_done || done_set;
    end
  end

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
  parameter int                NUM_ROWS  = 4,
  parameter int                ADDR_W    = 13,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] MODE_VAL  = 13'h1D0,
  parameter logic [DATA_W-1:0] CHECK_PAT = 32'h55AA55AA
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_vld,
  input logic [2:0]          cmd_mode,
  input logic [NUM_ROWS-1:0] cs_n,
  input logic [ADDR_W-1:0]   addr,
  input logic                wr_en,
  input logic                rd_en,
  input logic [DATA_W-1:0]   wdata,
  input logic                refresh_en,
  input logic                init_done,
  input logic [NUM_ROWS-1:0] row_err
);

  assert_one_row_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    $countones({cmd_vld, wr_en, rd_en}) <= 1);

  assert_cs_with_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld || wr_en || rd_en) == (cs_n != '1));

  assert_read_after_write_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_en && $stable(cs_n)));

  assert_mode_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_mode == 3'd3) |-> addr == MODE_VAL);

  assert_pattern_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wdata == CHECK_PAT && addr == '0));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((row_err & $past(row_err)) == $past(row_err)));

  assert_done_after_refresh_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> $past(refresh_en));

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (!cmd_vld && !wr_en && !rd_en && refresh_en));

  assert_done_holds_R9: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_mode_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !cmd_vld |=> (!cmd_vld -> $stable(cmd_mode)));

endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
  .NUM_ROWS  (NUM_ROWS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .MODE_VAL  (MODE_VAL),
  .CHECK_PAT (CHECK_PAT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_vld    (cmd_vld),
  .cmd_mode   (cmd_mode),
  .cs_n       (cs_n),
  .addr       (addr),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .wdata      (wdata),
  .refresh_en (refresh_en),
  .init_done  (init_done),
  .row_err    (row_err)
);

// File: tb/sdram_pwrup_seq_bench.sv
module sdram_pwrup_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int KHZ        = 5500;
  localparam int RD_LAT     = 2;
  localparam int ROWS       = 4;
  // Wait lengths worked out by hand for 5500 kHz (R10).
  localparam int T1   = 6;
  localparam int T2   = 11;
  localparam int T200 = 1100;
  localparam logic [31:0] PAT  = 32'h55AA55AA;
  localparam logic [31:0] JUNK = 32'hDEAD0BAD;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] row_bound = '0;
  logic [31:0] rd_data = JUNK;
  logic        cmd_vld, wr_en, rd_en, refresh_en, init_done;
  logic [2:0]  cmd_mode;
  logic [3:0]  cs_n, row_err;
  logic [12:0] addr;
  logic [31:0] wdata;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  int q_gap[$];
  int q_kind[$];
  int q_row[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_pwrup_seq #(.CLK_KHZ(KHZ), .RD_LAT(RD_LAT)) u_sdram_pwrup_seq (
    .clk(clk), .rst(rst), .row_bound(row_bound), .rd_data(rd_data),
    .cmd_vld(cmd_vld), .cmd_mode(cmd_mode), .cs_n(cs_n), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .refresh_en(refresh_en),
    .init_done(init_done), .row_err(row_err)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at t=%0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic push(input int g, input int k, input int r);
    q_gap.push_back(g);
    q_kind.push_back(k);
    q_row.push_back(r);
  endtask

  // kinds: 0..7 command mode codes, 8 write, 9 read, 10 refresh on, 11 done
  task automatic run_case(input logic [31:0] bnd, input int bad_row);
    int g, prev, cd, kind, erow, pend, rcd, rrow, k, t_pre;
    logic [31:0] mem [ROWS];
    logic [2:0]  e_mode;
    logic [3:0]  e_err;
    bit          e_ref, e_done, strobe;

    q_gap.delete(); q_kind.delete(); q_row.delete();
    prev = 0;
    g = T200;
    for (int r = 0; r < ROWS; r++) begin
      int b = int'(bnd[r*8 +: 8]);
      if (b > prev) begin  // R3: populated only when above the row below
        push(g, 1, r);
        push(T200, 2, r);
        for (int i = 0; i < 8; i++) push(T1, 6, r);
        push(T1, 3, r);
        push(T2, 7, r);
        push(T1, 8, r);
        push(1, 9, r);
        g = RD_LAT + 1;
      end
      prev = b;
    end
    push(g, 10, 0);
    push(1, 11, 0);

    rst = 1'b1;
    row_bound = bnd;
    rd_data = JUNK;
    for (int r = 0; r < ROWS; r++) mem[r] = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(cmd_vld == 0 && wr_en == 0 && rd_en == 0, "R1 strobes", {cmd_vld, wr_en, rd_en}, 0);
    chk(cs_n == 4'hF, "R1 cs_n", cs_n, 4'hF);
    chk(cmd_mode == 3'd1, "R1 cmd_mode", cmd_mode, 1);
    chk(addr == 0 && wdata == 0, "R1 addr/wdata", addr, 0);
    chk(refresh_en == 0 && init_done == 0 && row_err == 0, "R1 flags",
        {refresh_en, init_done, row_err}, 0);
    rst = 1'b0;

    cd = q_gap[0];
    e_mode = 3'd1; e_err = '0; e_ref = 0; e_done = 0;
    pend = -1; rcd = 0; rrow = 0; k = 0; t_pre = -1;
    while (q_gap.size() > 0 || k < 12) begin
      @(negedge clk);
      kind = -1; erow = 0;
      if (q_gap.size() > 0) begin
        cd--;
        if (cd == 0) begin
          kind = q_kind.pop_front();
          erow = q_row.pop_front();
          void'(q_gap.pop_front());
          if (q_gap.size() > 0) cd = q_gap[0];
          if (pend >= 0) begin e_err[pend] = 1'b1; pend = -1; end
          if (kind == 9 && erow == bad_row) pend = erow;
          if (kind <= 7) e_mode = 3'(kind);
          if (kind == 10) e_ref = 1;
          if (kind == 11) e_done = 1;
        end
      end else begin
        k++;
      end
      strobe = (kind >= 0 && kind <= 9);
      chk(cmd_vld == (kind >= 0 && kind <= 7), "R2/R4/R5 cmd_vld", cmd_vld, (kind >= 0 && kind <= 7));
      chk(cmd_mode == e_mode, "R4/R11 cmd_mode", cmd_mode, e_mode);
      chk(cs_n == (strobe ? ~(4'b1 << erow) : 4'hF), "R3/R4 cs_n", cs_n,
          strobe ? ~(4'b1 << erow) : 4'hF);
      chk(addr == ((kind == 3) ? 13'h1D0 : 13'h0), "R6 addr", addr, (kind == 3) ? 13'h1D0 : 0);
      chk(wr_en == (kind == 8), "R5 wr_en", wr_en, kind == 8);
      chk(rd_en == (kind == 9), "R5 rd_en", rd_en, kind == 9);
      chk(wdata == ((kind == 8) ? PAT : 32'h0), "R7 wdata", wdata, (kind == 8) ? PAT : 0);
      chk(refresh_en == e_ref, "R9 refresh_en", refresh_en, e_ref);
      chk(init_done == e_done, "R9 init_done", init_done, e_done);
      chk(row_err == e_err, "R8 row_err", row_err, e_err);

      // R10: explicit rounded-up spacings on the first row seen
      if (cmd_vld && cmd_mode == 3'd2 && t_pre < 0) t_pre = cyc;
      if (cmd_vld && cmd_mode == 3'd6 && t_pre > 0) begin
        chk(cyc - t_pre == 6, "R10 precharge-to-refresh", cyc - t_pre, 6);
        t_pre = 0;
      end

      // memory responder
      if (rcd > 0) begin
        rcd--;
        rd_data = (rcd == 0) ? (mem[rrow] ^ ((rrow == bad_row) ? 32'h1 : 32'h0)) : JUNK;
      end else begin
        rd_data = JUNK;
      end
      if (wr_en || rd_en) begin
        for (int r = 0; r < ROWS; r++) if (!cs_n[r]) rrow = r;
        if (wr_en) mem[rrow] = wdata;
        if (rd_en) rcd = RD_LAT;
      end
    end
  endtask

  initial begin
    // all rows populated, clean readbacks
    run_case({8'd8, 8'd6, 8'd4, 8'd2}, -1);
    // rows 1 and 3 populated (row 0 empty, row 2 equal); row 3 corrupted
    run_case({8'd8, 8'd4, 8'd4, 8'd0}, 3);
    // nothing populated: refresh after power wait only
    run_case(32'h0, -1);
    // decreasing boundary skips row 1, equal skips row 3; row 0 corrupted
    run_case({8'd6, 8'd6, 8'd2, 8'd4}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule